// File: doc/BRIEF.md
# Variable-Length Two-Address Processor Core

This block is a compact processor that runs programs out of a 256-byte memory of its own. Its instructions are one, two or three bytes long, and the first byte decides which length applies. Every data operand is a 32-bit word built from four consecutive bytes, with the most significant byte at the lowest address. A two-address instruction names a destination/first operand and a second operand. Arithmetic reads both words, computes, and writes the result over the first word.

A test harness fills the memory through a byte-wide load port while the core is not running. It then pulses `go`, and the core starts at address 0. The harness waits for the `halted` or `fault` status and reads the results back through a combinational peek port. One instruction is processed as a fixed series of steps, each moving one byte per cycle:

- fetch the instruction bytes;
- read the first operand word (when the opcode needs it);
- read the second operand word (when the opcode needs it);
- execute;
- write the result back (when the opcode writes memory).

The program counter moves past the instruction as its bytes are fetched. Memory contents are not cleared by reset.

Top module: `vl2a_core`

## Requirements
- R1: While reset is held and until `go` is sampled high, `running`, `halted` and `fault` are low and `pc` is 0. A `go` pulse starts execution at address 0.
- R2: The legal first bytes are 0x00, 0x01, 0x02, 0x03, 0x04, 0x05, 0x13, 0x14, 0x80 to 0x86, 0x93 to 0x96 and 0x99. Any other first byte drives the core to the fault status.
- R3: The instruction lengths are as follows, and `pc` advances by one for every fetched byte. The halt byte still moves `pc` one past itself before `halted` rises.
  - 0x00 to 0x05, 0x13 and 0x14 are three bytes: opcode, first address, second address.
  - 0x80 to 0x86 and 0x93 to 0x96 are two bytes: opcode, target.
  - 0x99 is one byte.
- R4: The arithmetic instructions write their result, the low 32 bits, over the word at the first address. They are 0x01 (first+second), 0x02 (first-second), 0x03 (signed product) and 0x13 (unsigned product). Words are big-endian across four bytes.
- R5: 0x00 copies the word at the second address into the first address.
- R6: The divide instructions are 0x04 (signed, quotient truncated toward zero, remainder carrying the dividend's sign) and 0x14 (unsigned). Each writes the quotient at the first address and the remainder at the first address + 4. No other byte is written.
- R7: A divide whose divisor is zero raises `fault` and writes no memory.
- R8: 0x05 compares first with second and writes no memory. It records three flags, which reset clears and which no other instruction changes: equal, signed-less and unsigned-less.
- R9: Conditional jumps load `pc` with the target when their condition on the recorded flags holds; otherwise execution continues after the jump. The conditions are:
  - 0x81: equal; 0x82: not equal.
  - Signed: 0x83 less, 0x84 greater-or-equal, 0x85 less-or-equal, 0x86 greater.
  - Unsigned: 0x93 less, 0x94 greater-or-equal, 0x95 less-or-equal, 0x96 greater.
  - 0x80 always jumps.
- R10: The following raise `fault` before any write:
  - an operand word that would extend past byte 255 (first or second address above 252);
  - a divide whose first address is above 248;
  - an instruction whose remaining bytes would be fetched past byte 255.
- R11: The load port writes a byte only while the core is not running. The peek port reads any byte at any time.
- R12: `halted` and `fault` are mutually exclusive with `running`, stay set until reset, and freeze `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | Start pulse, honoured only in the idle state |
| ld_we | input | 1 | Load-port byte write enable |
| ld_addr | input | 8 | Load-port byte address |
| ld_data | input | 8 | Load-port byte value |
| pk_addr | input | 8 | Peek-port byte address |
| pk_data | output | 8 | Byte stored at `pk_addr` |
| pc | output | 8 | Program counter |
| running | output | 1 | Core is executing |
| halted | output | 1 | Halt instruction reached |
| fault | output | 1 | Illegal opcode, divide by zero or out-of-range access |

## Verification
The bench goes after the corner cases below and names what a wrong design would show for each:

- **Signed and unsigned readings of the same bytes.** A core that used the wrong reading would pick the wrong branch of a jump, or write a wrong product or quotient.
- **Divide results.** A core that misplaced the remainder, or wrote a second word for non-divide opcodes, would clobber the canary word at first+4.
- **Boundary addresses.** The bench uses word addresses 252 and 253, a jump into byte 255 that needs more bytes, and a halt that must still step `pc`. An off-by-one range check or PC update shows up there as a missing or spurious fault, or a wrong final `pc`.
- **Side effects that must not happen.** Compare must not write memory, an arithmetic result must not disturb the compare flags, and a load-port write must not land while a program spins. A leak of any of these is visible at the peek port or in the jump taken.

// File: rtl/vl2a_pkg.sv
// Package: opcode encoding, control states and decode helpers shared by the
// core. Assumes the encoding is fixed: one opcode byte, byte-wide addresses.
package vl2a_pkg;
    localparam int AW = 8;                 // address field = one instruction byte

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_RDA, S_RDB, S_EXEC, S_WRB, S_HALT, S_FAULT
    } cpu_state_t;

    localparam logic [7:0] OP_MOVE = 8'h00;
    localparam logic [7:0] OP_ADD  = 8'h01;
    localparam logic [7:0] OP_SUB  = 8'h02;
    localparam logic [7:0] OP_SMUL = 8'h03;
    localparam logic [7:0] OP_SDIV = 8'h04;
    localparam logic [7:0] OP_CMP  = 8'h05;
    localparam logic [7:0] OP_UMUL = 8'h13;
    localparam logic [7:0] OP_UDIV = 8'h14;
    localparam logic [7:0] OP_HALT = 8'h99;

    // True for a jump opcode (unconditional or conditional)
    function automatic logic is_jump(input logic [7:0] b);
        return (b >= 8'h80 && b <= 8'h86) || (b >= 8'h93 && b <= 8'h96);
    endfunction

    // True for any opcode the core accepts
    function automatic logic is_legal(input logic [7:0] b);
        return (b <= 8'h05) || b == OP_UMUL || b == OP_UDIV || b == OP_HALT || is_jump(b);
    endfunction

    function automatic logic is_div(input logic [7:0] b);
        return b == OP_SDIV || b == OP_UDIV;
    endfunction
endpackage

// File: rtl/vl2a_mem.sv
// Behavioural byte memory of 2**AW entries, no reset.
// Core write port takes priority over the load port; the caller gates the
// load port while running. Reads are combinational.
module vl2a_mem #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cw_en,
    input  logic [AW:0]   cw_addr,
    input  logic [7:0]    cw_data,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_data,
    input  logic [AW-1:0] cr_addr,
    output logic [7:0]    cr_data,
    input  logic [AW-1:0] pk_addr,
    output logic [7:0]    pk_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    // Single write port shared by core write-back and test loading
    always_ff @(posedge clk) begin
        if (cw_en)
            mem_q[cw_addr[AW-1:0]] <= cw_data;
        else if (ld_en)
            mem_q[ld_addr] <= ld_data;
    end

    assign cr_data = mem_q[cr_addr];
    assign pk_data = mem_q[pk_addr];

    // Write-back never reaches past the top byte
    AST_WR_INRANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cw_en |-> !cw_addr[AW]);  // R10
endmodule

// File: rtl/vl2a_alu.sv
// Combinational datapath: move, add, subtract, low-word multiply,
// signed/unsigned divide with remainder, and compare flags.
// Assumes the caller never uses the divide result when divz is set.
module vl2a_alu #(
    parameter int DW = 32
) (
    input  logic [7:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res_lo,
    output logic [DW-1:0] res_hi,
    output logic          divz,
    output logic          f_eq,
    output logic          f_slt,
    output logic          f_ult
);
    import vl2a_pkg::*;

    logic [DW-1:0]        bs;
    logic signed [DW-1:0] sa, sb;
    logic [DW-1:0]        prod;

    assign divz = (b == '0);
    assign bs   = divz ? DW'(1) : b;
    assign sa   = $signed(a);
    assign sb   = $signed(bs);
    assign prod = a * b;   // low word is identical for signed and unsigned

    // Result select by opcode
    always_comb begin
        res_lo = b;
        res_hi = '0;
        case (op)
            OP_ADD:  res_lo = a + b;
            OP_SUB:  res_lo = a - b;
            OP_SMUL,
            OP_UMUL: res_lo = prod;
            OP_SDIV: begin
                res_lo = $unsigned(sa / sb);
                res_hi = $unsigned(sa % sb);
            end
            OP_UDIV: begin
                res_lo = a / bs;
                res_hi = a % bs;
            end
            default: res_lo = b;
        endcase
    end

    assign f_eq  = (a == b);
    assign f_slt = ($signed(a) < $signed(b));
    assign f_ult = (a < b);
endmodule

// File: rtl/vl2a_cond.sv
// Jump-condition evaluator: decides from the stored compare flags whether a
// jump opcode is taken. Non-jump opcodes never report taken.
module vl2a_cond (
    input  logic [7:0] op,
    input  logic       f_eq,
    input  logic       f_slt,
    input  logic       f_ult,
    output logic       take
);
    // Condition table
    always_comb begin
        case (op)
            8'h80:   take = 1'b1;
            8'h81:   take = f_eq;
            8'h82:   take = !f_eq;
            8'h83:   take = f_slt;
            8'h84:   take = !f_slt;
            8'h85:   take = f_slt || f_eq;
            8'h86:   take = !(f_slt || f_eq);
            8'h93:   take = f_ult;
            8'h94:   take = !f_ult;
            8'h95:   take = f_ult || f_eq;
            8'h96:   take = !(f_ult || f_eq);
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/vl2a_core.sv
// Top: control FSM for the variable-length two-address core. Moves one
// memory byte per cycle through fetch, operand reads and write-back.
// Assumes memory is loaded while idle and that go is a short pulse.
module vl2a_core #(
    parameter int DW = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go,
    input  logic                   ld_we,
    input  logic [vl2a_pkg::AW-1:0] ld_addr,
    input  logic [7:0]             ld_data,
    input  logic [vl2a_pkg::AW-1:0] pk_addr,
    output logic [7:0]             pk_data,
    output logic [vl2a_pkg::AW-1:0] pc,
    output logic                   running,
    output logic                   halted,
    output logic                   fault
);
    import vl2a_pkg::*;

    localparam int BPW   = DW / 8;
    localparam int DEPTH = 1 << AW;
    localparam int CW    = $clog2(2 * BPW);
    localparam int IW    = $clog2(BPW);
    localparam logic [AW:0]   LIM1  = (AW+1)'(DEPTH - BPW);
    localparam logic [AW:0]   LIM2  = (AW+1)'(DEPTH - 2 * BPW);
    localparam logic [AW-1:0] TOP   = AW'(DEPTH - 1);
    localparam logic [CW-1:0] LASTW = CW'(BPW - 1);
    localparam logic [CW-1:0] LASTD = CW'(2 * BPW - 1);

    cpu_state_t    state, state_n;
    logic [CW-1:0] cnt;
    logic [AW-1:0] pc_q, a1, a2, cr_addr;
    logic [7:0]    op, cr_data, cw_data;
    logic [DW-1:0] opa, opb, res0, res1, alu_lo, alu_hi, wsel, wsh;
    logic          f_eq, f_slt, f_ult, n_eq, n_slt, n_ult, divz, take;
    logic          range_bad, cw_en;

    vl2a_mem #(.AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .cw_en(cw_en), .cw_addr({1'b0, a1} + (AW+1)'(cnt)), .cw_data(cw_data),
        .ld_en(ld_we && !running), .ld_addr(ld_addr), .ld_data(ld_data),
        .cr_addr(cr_addr), .cr_data(cr_data),
        .pk_addr(pk_addr), .pk_data(pk_data)
    );

    vl2a_alu #(.DW(DW)) u_alu (
        .op(op), .a(opa), .b(opb), .res_lo(alu_lo), .res_hi(alu_hi),
        .divz(divz), .f_eq(n_eq), .f_slt(n_slt), .f_ult(n_ult)
    );

    vl2a_cond u_cond (
        .op(op), .f_eq(f_eq), .f_slt(f_slt), .f_ult(f_ult), .take(take)
    );

    // Read address: PC while fetching, operand base plus byte index otherwise
    always_comb begin
        case (state)
            S_RDA:   cr_addr = a1 + AW'(cnt);
            S_RDB:   cr_addr = a2 + AW'(cnt);
            default: cr_addr = pc_q;
        endcase
    end

    // Operand words must fit below the top of memory; cr_data is the second address
    assign range_bad = ({1'b0, a1} > LIM1) || ({1'b0, cr_data} > LIM1) ||
                       (is_div(op) && ({1'b0, a1} > LIM2));

    // Write-back byte: quotient/result word first, remainder word second, MSB first
    assign wsel    = (cnt < CW'(BPW)) ? res0 : res1;
    assign wsh     = wsel << {cnt[IW-1:0], 3'b000};
    assign cw_data = wsh[DW-1 -: 8];
    assign cw_en   = (state == S_WRB);

    // Next-state decision
    always_comb begin
        state_n = state;
        case (state)
            S_IDLE:  if (go) state_n = S_FETCH;
            S_FETCH: begin
                if (cnt == '0) begin
                    if (!is_legal(cr_data))    state_n = S_FAULT;
                    else if (cr_data == OP_HALT) state_n = S_HALT;
                    else if (pc_q == TOP)      state_n = S_FAULT;
                end else if (cnt == CW'(1)) begin
                    if (is_jump(op))           state_n = S_EXEC;
                    else if (pc_q == TOP)      state_n = S_FAULT;
                end else begin
                    if (range_bad)             state_n = S_FAULT;
                    else if (op == OP_MOVE)    state_n = S_RDB;
                    else                       state_n = S_RDA;
                end
            end
            S_RDA:   if (cnt == LASTW) state_n = S_RDB;
            S_RDB:   if (cnt == LASTW) state_n = S_EXEC;
            S_EXEC: begin
                if (is_jump(op) || op == OP_CMP) state_n = S_FETCH;
                else if (is_div(op) && divz)    state_n = S_FAULT;
                else                            state_n = S_WRB;
            end
            S_WRB:   if (cnt == (is_div(op) ? LASTD : LASTW)) state_n = S_FETCH;
            default: state_n = state;
        endcase
    end

    // State, PC, instruction fields, operands, results and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
            pc_q  <= '0;
            op    <= '0;
            a1    <= '0;
            a2    <= '0;
            opa   <= '0;
            opb   <= '0;
            res0  <= '0;
            res1  <= '0;
            f_eq  <= 1'b0;
            f_slt <= 1'b0;
            f_ult <= 1'b0;
        end else begin
            state <= state_n;
            case (state)
                S_FETCH: begin
                    pc_q <= pc_q + 1'b1;
                    cnt  <= (state_n == S_FETCH) ? cnt + 1'b1 : '0;
                    if (cnt == '0)          op <= cr_data;
                    else if (cnt == CW'(1)) a1 <= cr_data;
                    else                    a2 <= cr_data;
                end
                S_RDA: begin
                    opa <= {opa[DW-9:0], cr_data};
                    cnt <= (cnt == LASTW) ? '0 : cnt + 1'b1;
                end
                S_RDB: begin
                    opb <= {opb[DW-9:0], cr_data};
                    cnt <= (cnt == LASTW) ? '0 : cnt + 1'b1;
                end
                S_EXEC: begin
                    if (take) pc_q <= a1;
                    if (op == OP_CMP) begin
                        f_eq  <= n_eq;
                        f_slt <= n_slt;
                        f_ult <= n_ult;
                    end
                    res0 <= alu_lo;
                    res1 <= alu_hi;
                    cnt  <= '0;
                end
                S_WRB:   cnt <= (state_n == S_WRB) ? cnt + 1'b1 : '0;
                default: cnt <= '0;
            endcase
        end
    end

    assign pc      = pc_q;
    assign running = (state != S_IDLE) && (state != S_HALT) && (state != S_FAULT);
    assign halted  = (state == S_HALT);
    assign fault   = (state == S_FAULT);

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && $stable(pc));  // R12
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault && !running && $stable(pc));  // R12
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH && state_n != S_FAULT) |=> pc == $past(pc) + 1'b1);  // R3
    AST_CMP_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && op == OP_CMP) |=> !cw_en);  // R8
    AST_DIVZ_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && is_div(op) && divz) |=> fault);  // R7
endmodule

// File: tb/sim_vl2a_core.sv
module sim_vl2a_core;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;
    localparam logic [31:0] CANARY = 32'h5A5A5A5A;
    // {opcode, first word, second word, expected word @0x10, expected word @0x14}
    localparam logic [135:0] VEC [NV] = '{
        {8'h01, 32'h0000000C, 32'h0000000A, 32'h00000016, CANARY},
        {8'h01, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, CANARY},
        {8'h02, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, CANARY},
        {8'h03, 32'hFFFFFFEB, 32'hFFFFFF85, 32'h00000A17, CANARY},
        {8'h13, 32'h00010000, 32'h00010001, 32'h00010000, CANARY},
        {8'h04, 32'hFFFFFF9C, 32'h00000007, 32'hFFFFFFF2, 32'hFFFFFFFE},
        {8'h14, 32'hFFFFFF9C, 32'h00000007, 32'h24924916, 32'h00000002},
        {8'h00, 32'h000004D2, 32'hDEADBEEF, 32'hDEADBEEF, CANARY},
        {8'h05, 32'h00000003, 32'h00000004, 32'h00000003, CANARY}
    };

    logic       clk = 1'b0, rst_n = 1'b0, go = 1'b0, ld_we = 1'b0;
    logic [7:0] ld_addr = '0, ld_data = '0, pk_addr = '0;
    logic [7:0] pk_data, pc;
    logic       running, halted, fault;
    int         n_chk = 0, n_bad = 0, cyc = 0;
    bit         done = 1'b0;

    vl2a_core u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .pk_addr(pk_addr), .pk_data(pk_data), .pc(pc),
        .running(running), .halted(halted), .fault(fault)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic put_b(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk) ld_we = 1'b0;
    endtask

    task automatic put_w(input logic [7:0] a, input logic [31:0] w);
        for (int k = 0; k < 4; k++) put_b(a + 8'(k), w[31 - 8 * k -: 8]);
    endtask

    task automatic get_w(input logic [7:0] a, output logic [31:0] w);
        w = '0;
        for (int k = 0; k < 4; k++) begin
            pk_addr = a + 8'(k);
            #1 w = {w[23:0], pk_data};
        end
    endtask

    task automatic run_prog();
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
        for (int t = 0; t < 2000 && !(halted || fault); t++) @(negedge clk);
        #1;
    endtask

    function automatic logic jexp(input logic [7:0] o, input logic [31:0] a, input logic [31:0] b);
        logic eq = (a == b), sl = ($signed(a) < $signed(b)), ul = (a < b);
        case (o)
            8'h81: return eq;
            8'h82: return !eq;
            8'h83: return sl;
            8'h84: return !sl;
            8'h85: return sl || eq;
            8'h86: return !(sl || eq);
            8'h93: return ul;
            8'h94: return !ul;
            8'h95: return ul || eq;
            8'h96: return !(ul || eq);
            default: return 1'b1;
        endcase
    endfunction

    initial begin
        logic [31:0] w;
        logic [7:0]  jops [11] = '{8'h80, 8'h81, 8'h82, 8'h83, 8'h84, 8'h85,
                                   8'h86, 8'h93, 8'h94, 8'h95, 8'h96};
        logic [31:0] pa [3] = '{32'h5, 32'hFFFFFFFF, 32'h7};
        logic [31:0] pb [3] = '{32'h5, 32'h1, 32'h3};
        logic [7:0]  bad_ops [5] = '{8'h06, 8'h12, 8'h87, 8'h98, 8'hFF};

        // R1: reset state, nothing starts without go
        do_reset();
        repeat (3) @(negedge clk);
        #1;
        chk("R1 status", {29'd0, running, halted, fault}, 32'd0);
        chk("R1 pc", {24'd0, pc}, 32'd0);

        // R4 R5 R6 R8: vector table, program "op 10 20 ; halt"
        for (int i = 0; i < NV; i++) begin
            do_reset();
            put_b(8'h00, VEC[i][135:128]); put_b(8'h01, 8'h10); put_b(8'h02, 8'h20);
            put_b(8'h03, 8'h99);
            put_w(8'h10, VEC[i][127:96]); put_w(8'h14, CANARY); put_w(8'h20, VEC[i][95:64]);
            run_prog();
            get_w(8'h10, w); chk($sformatf("R4 R5 R6 R8 first word op=%h", VEC[i][135:128]), w, VEC[i][63:32]);
            get_w(8'h14, w); chk($sformatf("R6 next word op=%h", VEC[i][135:128]), w, VEC[i][31:0]);
            chk("R3 halt pc after 3-byte op", {22'd0, halted, fault, pc}, {22'd0, 2'b10, 8'h04});
        end

        // R9: compare then jump; taken halts at 9, fallthrough halts at 6
        for (int j = 0; j < 11; j++) begin
            for (int p = 0; p < 3; p++) begin
                do_reset();
                put_b(8'h00, 8'h05); put_b(8'h01, 8'h10); put_b(8'h02, 8'h20);
                put_b(8'h03, jops[j]); put_b(8'h04, 8'h08);
                put_b(8'h05, 8'h99); put_b(8'h08, 8'h99);
                put_w(8'h10, pa[p]); put_w(8'h20, pb[p]);
                run_prog();
                chk($sformatf("R9 jump op=%h a=%h b=%h", jops[j], pa[p], pb[p]), {24'd0, pc},
                    jexp(jops[j], pa[p], pb[p]) ? 32'd9 : 32'd6);
            end
        end

        // R8: flags cleared by reset, so jump-if-equal first falls through to pc 3
        do_reset();
        put_b(8'h00, 8'h81); put_b(8'h01, 8'h04); put_b(8'h02, 8'h99); put_b(8'h04, 8'h99);
        run_prog();
        chk("R8 flags clear after reset", {24'd0, pc}, 32'd3);

        // R8: add between compare(equal) and jeq leaves flags, jump taken to 0x0B, halt pc 0x0C
        do_reset();
        put_b(8'h00, 8'h05); put_b(8'h01, 8'h10); put_b(8'h02, 8'h20);
        put_b(8'h03, 8'h01); put_b(8'h04, 8'h10); put_b(8'h05, 8'h24);
        put_b(8'h06, 8'h81); put_b(8'h07, 8'h0B); put_b(8'h08, 8'h99); put_b(8'h0B, 8'h99);
        put_w(8'h10, 32'd5); put_w(8'h20, 32'd5); put_w(8'h24, 32'd1);
        run_prog();
        chk("R8 flags kept across add", {24'd0, pc}, 32'h0C);

        // R3: lone halt at 0 moves pc to 1
        do_reset();
        put_b(8'h00, 8'h99);
        run_prog();
        chk("R3 halt-only pc", {23'd0, halted, pc}, {23'd0, 1'b1, 8'h01});
        chk("R12 running low when halted", {31'd0, running}, 32'd0);

        // R2: illegal first bytes fault
        foreach (bad_ops[k]) begin
            do_reset();
            put_b(8'h00, bad_ops[k]);
            run_prog();
            chk($sformatf("R2 illegal op=%h", bad_ops[k]), {30'd0, halted, fault}, 32'd1);
        end

        // R7: divide by zero faults, first word untouched
        do_reset();
        put_b(8'h00, 8'h04); put_b(8'h01, 8'h10); put_b(8'h02, 8'h20); put_b(8'h03, 8'h99);
        put_w(8'h10, 32'h00001234); put_w(8'h20, 32'd0);
        run_prog();
        chk("R7 div-zero fault", {31'd0, fault}, 32'd1);
        get_w(8'h10, w); chk("R7 no write on div-zero", w, 32'h00001234);

        // R10: word at 0xFD exceeds memory
        do_reset();
        put_b(8'h00, 8'h01); put_b(8'h01, 8'hFD); put_b(8'h02, 8'h20); put_b(8'h03, 8'h99);
        run_prog();
        chk("R10 word past top", {31'd0, fault}, 32'd1);

        // R10: divide at 0xF9 needs a second word past top
        do_reset();
        put_b(8'h00, 8'h14); put_b(8'h01, 8'hF9); put_b(8'h02, 8'h20);
        put_w(8'h20, 32'd3);
        run_prog();
        chk("R10 divide second word past top", {31'd0, fault}, 32'd1);

        // R10: boundary word at 0xFC is legal
        do_reset();
        put_b(8'h00, 8'h01); put_b(8'h01, 8'hFC); put_b(8'h02, 8'h20); put_b(8'h03, 8'h99);
        put_w(8'hFC, 32'd1); put_w(8'h20, 32'd1);
        run_prog();
        get_w(8'hFC, w); chk("R10 top word add", w, 32'd2);
        chk("R10 top word no fault", {31'd0, halted}, 32'd1);

        // R10: jump to 0xFF where a 3-byte opcode cannot be fetched
        do_reset();
        put_b(8'h00, 8'h80); put_b(8'h01, 8'hFF); put_b(8'hFF, 8'h01);
        run_prog();
        chk("R10 fetch past top", {31'd0, fault}, 32'd1);

        // R11: load port ignored while a self-jump spins
        do_reset();
        put_b(8'h00, 8'h80); put_b(8'h01, 8'h00); put_b(8'h40, 8'h55);
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
        repeat (20) @(negedge clk);
        put_b(8'h40, 8'hAA);
        pk_addr = 8'h40;
        #1;
        chk("R11 load blocked while running", {23'd0, running, pk_data}, {23'd0, 1'b1, 8'h55});
        do_reset();
        put_b(8'h40, 8'hAA);
        pk_addr = 8'h40;
        #1;
        chk("R11 load accepted when idle", {24'd0, pk_data}, 32'h000000AA);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule